// File: doc/BRIEF.md
# Console transmit register pair

This block puts a console transmitter behind two CPU-visible registers: a status register holding a ready flag and an interrupt enable, and a write-only data buffer. Writing a character into the buffer marks the transmitter busy, withdraws any transmit interrupt and, after a programmable number of clock cycles, offers the byte to a serial back end through a one-cycle start strobe. The back end either takes the byte or refuses it with a stall in the same cycle. A refused byte is offered again after the same delay. An accepted byte makes the transmitter ready again, advances a character counter and raises the interrupt when enabled.

A mode input picks how characters leave the block: full 8-bit, 7-bit with the top bit cleared, or 7-bit with control characters dropped. A dropped character never reaches the back end, but the block completes it exactly as if the back end had taken it. The block comes out of reset ready, with interrupts disabled and nothing in flight.

Top module: `contx_regif`

## Requirements
- R1: After reset, and after a reset applied while a character is in flight, the status register reads 0x0080, the interrupt and start outputs are low, the character counter is zero, and no start strobe follows.
- R2: The status register presents the ready flag at bit 7 and the interrupt enable at bit 6. All other bits read zero, and only bit 6 can be written.
- R3: A write to the data address (addr_i = 1) clears the ready flag and the interrupt at the next edge. The start strobe rises exactly DELAY_CYC cycles after the write edge and stays low before that.
- R4: In 8-bit mode (mode_i = 0, and also mode_i = 3), the byte offered to the back end is the low 8 bits of the written data, and the upper data bits are ignored.
- R5: A start cycle without stall sets the ready flag and advances the counter by one at the next edge. The counter wraps at 2^CNT_W. The interrupt rises at that edge only when the enable is set.
- R6: Writing the enable as 0 drops a pending interrupt at the next edge. Writing it as 1 while ready with the enable clear raises the interrupt at the next edge.
- R7: A start cycle with tx_stall_i high leaves the ready flag clear. The same byte is offered again DELAY_CYC cycles after that edge.
- R8: In the 7-bit modes (mode_i = 1 and 2), the offered byte has bit 7 cleared.
- R9: In mode_i = 2, a character is dropped when its masked code is 0x7F, or when it is below 0x20 and is not 0x07, 0x08, 0x09, 0x0A or 0x0D. A dropped character raises no start strobe, yet the ready flag and counter behave as for an accepted character. Mode 0 sends such codes normally.
- R10: A data write while a character waits in the delay replaces that character and restarts the full delay. Only the new character is sent and counted.
- R11: rdata_o is zero unless a status read is selected. Reading the data address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 1 | 0 selects status, 1 selects data buffer |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational |
| mode_i | input | 2 | Output character mode |
| tx_start_o | output | 1 | One-cycle offer of tx_byte_o to the back end |
| tx_byte_o | output | 8 | Byte offered to the back end |
| tx_stall_i | input | 1 | Back end refuses the offered byte in the start cycle |
| irq_o | output | 1 | Transmit interrupt request |
| char_count_o | output | CNT_W | Completed character count |

## Verification
The bench builds the block with DELAY_CYC = 3 and CNT_W = 4. The short delay lets the bench check every cycle of the start window and the retry reload one by one. The narrow counter brings its wraparound within a couple of dozen characters. The stall, replacement and mid-flight reset cases all fall inside a few delay periods at these values.

// File: rtl/contx_pkg.sv
`timescale 1ns/1ps
package contx_pkg;
  localparam int BYTE_W  = 8;
  localparam int RDY_BIT = 7;
  localparam int IE_BIT  = 6;
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  typedef enum logic [1:0] {
    MODE_8B  = 2'd0,
    MODE_7B  = 2'd1,
    MODE_7NP = 2'd2,
    MODE_RSV = 2'd3
  } tx_mode_e;

  function automatic logic is_ctrl_drop(input logic [BYTE_W-1:0] c);
    logic keep;
    keep = (c == 8'h07) || (c == 8'h08) || (c == 8'h09) ||
           (c == 8'h0A) || (c == 8'h0D);
    return (c == 8'h7F) || ((c < 8'h20) && !keep);
  endfunction
endpackage

// File: rtl/contx_filter.sv
`timescale 1ns/1ps
module contx_filter
  import contx_pkg::*;
(
  input  logic [BYTE_W-1:0] raw_i,
  input  logic [1:0]        mode_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              drop_o
);
  tx_mode_e mode;
  logic     seven;

  always_comb begin
    mode   = tx_mode_e'(mode_i);
    seven  = (mode == MODE_7B) || (mode == MODE_7NP);
    byte_o = seven ? {1'b0, raw_i[BYTE_W-2:0]} : raw_i;
    drop_o = (mode == MODE_7NP) && is_ctrl_drop(byte_o);
  end
endmodule

// File: rtl/contx_launch.sv
`timescale 1ns/1ps
module contx_launch
  import contx_pkg::*;
#(
  parameter int DELAY_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_byte_i,
  input  logic              drop_i,
  input  logic              stall_i,
  output logic [BYTE_W-1:0] buf_o,
  output logic              start_o,
  output logic              complete_o
);
  localparam int DW = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC);
  localparam logic [DW-1:0] RELOAD = DW'(DELAY_CYC - 1);

  logic [BYTE_W-1:0] buf_q;
  logic [DW-1:0]     cnt_q;
  logic              pend_q;
  logic              launch, retry;

  // a new load in the launch cycle wins: the old byte is never offered
  assign launch     = pend_q && (cnt_q == '0) && !load_i;
  assign start_o    = launch && !drop_i;
  assign complete_o = launch && (drop_i || !stall_i);
  assign retry      = launch && !drop_i && stall_i;
  assign buf_o      = buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (load_i) begin
      buf_q  <= load_byte_i;
      cnt_q  <= RELOAD;
      pend_q <= 1'b1;
    end else if (complete_o) begin
      pend_q <= 1'b0;
    end else if (retry) begin
      cnt_q  <= RELOAD;
    end else if (pend_q && (cnt_q != '0)) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/contx_csr.sv
`timescale 1ns/1ps
module contx_csr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_wr_i,
  input  logic stat_wr_i,
  input  logic ie_wdata_i,
  input  logic complete_i,
  output logic done_o,
  output logic ie_o,
  output logic irq_o
);
  logic done_q, ie_q, irq_q;
  logic done_d, ie_d, irq_d;

  always_comb begin
    ie_d   = stat_wr_i ? ie_wdata_i : ie_q;
    done_d = done_q;
    irq_d  = irq_q;
    if (data_wr_i) begin
      done_d = 1'b0;
      irq_d  = 1'b0;
    end else if (complete_i) begin
      done_d = 1'b1;
      irq_d  = ie_d;
    end else if (stat_wr_i) begin
      irq_d  = ie_wdata_i && (irq_q || (done_q && !ie_q));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b1;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      ie_q   <= ie_d;
      irq_q  <= irq_d;
    end
  end

  assign done_o = done_q;
  assign ie_o   = ie_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/contx_count.sv
`timescale 1ns/1ps
module contx_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/contx_regif.sv
`timescale 1ns/1ps
module contx_regif
  import contx_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DELAY_CYC = 8,
  parameter int CNT_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [1:0]        mode_i,
  output logic              tx_start_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  input  logic              tx_stall_i,
  output logic              irq_o,
  output logic [CNT_W-1:0]  char_count_o
);
  logic              data_wr, stat_wr, stat_rd;
  logic              done_q, ie_q, complete, drop;
  logic [BYTE_W-1:0] buf_byte;

  assign data_wr = sel_i && wr_i && (addr_i == ADDR_DATA);
  assign stat_wr = sel_i && wr_i && (addr_i == ADDR_STAT);
  assign stat_rd = sel_i && rd_i && (addr_i == ADDR_STAT);

  contx_launch #(.DELAY_CYC(DELAY_CYC)) u_launch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (data_wr),
    .load_byte_i (wdata_i[BYTE_W-1:0]),
    .drop_i      (drop),
    .stall_i     (tx_stall_i),
    .buf_o       (buf_byte),
    .start_o     (tx_start_o),
    .complete_o  (complete)
  );

  contx_filter u_filter (
    .raw_i  (buf_byte),
    .mode_i (mode_i),
    .byte_o (tx_byte_o),
    .drop_o (drop)
  );

  contx_csr u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_wr_i  (data_wr),
    .stat_wr_i  (stat_wr),
    .ie_wdata_i (wdata_i[IE_BIT]),
    .complete_i (complete),
    .done_o     (done_q),
    .ie_o       (ie_q),
    .irq_o      (irq_o)
  );

  contx_count #(.CNT_W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (complete),
    .count_o (char_count_o)
  );

  always_comb begin
    rdata_o = '0;
    if (stat_rd) begin
      rdata_o[RDY_BIT] = done_q;
      rdata_o[IE_BIT]  = ie_q;
    end
  end
endmodule

// File: rtl/contx_chk.sv
`timescale 1ns/1ps
module contx_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             data_wr,
  input logic             done_q,
  input logic             ie_q,
  input logic             irq_o,
  input logic             tx_start_o,
  input logic             tx_stall_i,
  input logic [7:0]       tx_byte_o,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] char_count_o
);
  p_wr_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> (!done_q && !irq_o));

  p_start_while_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> !done_q);

  p_accept_completes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_o && !tx_stall_i) |=>
      (done_q && (char_count_o == $past(char_count_o) + CNT_W'(1))));

  p_irq_matches_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (done_q && ie_q));

  p_stall_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_o && tx_stall_i) |=> (!done_q && $stable(char_count_o)));

  p_seven_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_o && (mode_i == 2'd1 || mode_i == 2'd2)) |-> !tx_byte_o[7]);
endmodule

bind contx_regif contx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .data_wr      (data_wr),
  .done_q       (done_q),
  .ie_q         (ie_q),
  .irq_o        (irq_o),
  .tx_start_o   (tx_start_o),
  .tx_stall_i   (tx_stall_i),
  .tx_byte_o    (tx_byte_o),
  .mode_i       (mode_i),
  .char_count_o (char_count_o)
);

// File: tb/contx_regif_tb_top.sv
`timescale 1ns/1ps
module contx_regif_tb_top;
  localparam int DATA_W = 16;
  localparam int DLY    = 3;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sel_i = 0, wr_i = 0, rd_i = 0, addr_i = 0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic [1:0]        mode_i = 2'd0;
  logic              tx_start_o, tx_stall_i = 1'b0, irq_o;
  logic [7:0]        tx_byte_o;
  logic [CNT_W-1:0]  char_count_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0]       exp_q[$];
  logic [CNT_W-1:0] exp_cnt = '0;

  always #10 clk = ~clk;

  contx_regif #(.DATA_W(DATA_W), .DELAY_CYC(DLY), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .mode_i(mode_i),
    .tx_start_o(tx_start_o), .tx_byte_o(tx_byte_o), .tx_stall_i(tx_stall_i),
    .irq_o(irq_o), .char_count_o(char_count_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [DATA_W-1:0] d);
    sel_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    sel_i = 0; wr_i = 0; wdata_i = '0;
  endtask

  task automatic bus_rd(input logic a, output logic [DATA_W-1:0] v);
    sel_i = 1; rd_i = 1; addr_i = a;
    #1 v = rdata_o;
    sel_i = 0; rd_i = 0;
  endtask

  task automatic chk_stat(input logic [DATA_W-1:0] exp, input string req);
    logic [DATA_W-1:0] v;
    bus_rd(1'b0, v);
    chk(v == exp, req, v, exp);
  endtask

  // driver: pushes expected byte, writes, checks start timing and completion
  task automatic send(input logic [DATA_W-1:0] d, input bit drop,
                      input logic [7:0] eb, input bit ie, input string req);
    if (!drop) exp_q.push_back(eb);
    bus_wr(1'b1, d);
    for (int i = 0; i < DLY - 1; i++) begin
      chk(tx_start_o == 1'b0, {req, " early start"}, tx_start_o, 0);
      @(negedge clk);
    end
    chk(tx_start_o == !drop, {req, " start"}, tx_start_o, !drop);
    @(negedge clk);
    exp_cnt++;
    chk_stat({8'h00, 1'b1, ie, 6'h00}, {req, " ready R5"});
    chk(char_count_o == exp_cnt, "R5 count", char_count_o, exp_cnt);
    chk(irq_o == ie, "R5 irq", irq_o, ie);
  endtask

  // monitor: pops expected byte on every accepted start
  always @(negedge clk) begin
    #2;
    if (rst_ni && tx_start_o && !tx_stall_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9/R10 unexpected start", tx_byte_o, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(tx_byte_o == e, "R4/R8 byte", tx_byte_o, e);
      end
    end
  end

  initial begin
    #(20 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk_stat(16'h0080, "R1 status");
    chk(irq_o == 0 && tx_start_o == 0, "R1 outputs", {irq_o, tx_start_o}, 0);
    chk(char_count_o == 0, "R1 count", char_count_o, 0);
    // R11 read gating
    bus_rd(1'b1, v);
    chk(v == 0, "R11 data read", v, 0);
    sel_i = 0; rd_i = 1; addr_i = 0; #1;
    chk(rdata_o == 0, "R11 unselected", rdata_o, 0);
    rd_i = 0;
    // R2 / R6 enable handling
    bus_wr(1'b0, 16'hFFFF);
    chk_stat(16'h00C0, "R2 write all ones");
    chk(irq_o == 1, "R6 enable raises irq", irq_o, 1);
    bus_wr(1'b0, 16'hFFBF);
    chk_stat(16'h0080, "R2 only bit6 writable");
    chk(irq_o == 0, "R6 disable drops irq", irq_o, 0);
    // R3/R4 8-bit send with enable
    bus_wr(1'b0, 16'h0040);
    exp_q.push_back(8'hC3);
    bus_wr(1'b1, 16'hA5C3);
    chk_stat(16'h0040, "R3 busy after write");
    chk(irq_o == 0, "R3 irq cleared", irq_o, 0);
    for (int i = 0; i < DLY - 2; i++) @(negedge clk);
    chk(tx_start_o == 0, "R3 no start before delay", tx_start_o, 0);
    @(negedge clk);
    chk(tx_start_o == 1, "R3 start at delay", tx_start_o, 1);
    @(negedge clk);
    exp_cnt++;
    chk_stat(16'h00C0, "R5 ready with ie");
    chk(irq_o == 1, "R5 irq on completion", irq_o, 1);
    chk(char_count_o == exp_cnt, "R5 count", char_count_o, exp_cnt);
    // rest with ie=0
    bus_wr(1'b0, 16'h0000);
    send(16'h00C1, 0, 8'hC1, 0, "R4 mode0");
    mode_i = 2'd3;
    send(16'h12F0, 0, 8'hF0, 0, "R4 mode3");
    mode_i = 2'd1;
    send(16'h00C1, 0, 8'h41, 0, "R8 mode1");
    mode_i = 2'd2;
    send(16'h0085, 1, 8'h00, 0, "R9 drop 0x05");
    send(16'h000D, 0, 8'h0D, 0, "R9 keep CR");
    send(16'h0089, 0, 8'h09, 0, "R9 keep tab");
    send(16'h00FF, 1, 8'h00, 0, "R9 drop DEL");
    send(16'h0041, 0, 8'h41, 0, "R9 printable");
    mode_i = 2'd0;
    send(16'h0005, 0, 8'h05, 0, "R9 mode0 sends ctrl");
    // R7 stall and retry
    tx_stall_i = 1;
    exp_q.push_back(8'h4B);
    bus_wr(1'b1, 16'h004B);
    for (int i = 0; i < DLY - 1; i++) @(negedge clk);
    chk(tx_start_o == 1, "R7 first offer", tx_start_o, 1);
    @(negedge clk);
    chk_stat(16'h0000, "R7 not ready after stall");
    tx_stall_i = 0;
    for (int i = 0; i < DLY - 1; i++) begin
      chk(tx_start_o == 0, "R7 retry wait", tx_start_o, 0);
      @(negedge clk);
    end
    chk(tx_start_o == 1, "R7 retry offer", tx_start_o, 1);
    @(negedge clk);
    exp_cnt++;
    chk_stat(16'h0080, "R7 ready after retry");
    chk(char_count_o == exp_cnt, "R7 count once", char_count_o, exp_cnt);
    // R10 replacement
    exp_q.push_back(8'h22);
    bus_wr(1'b1, 16'h0011);
    chk(tx_start_o == 0, "R10 wait", tx_start_o, 0);
    bus_wr(1'b1, 16'h0022);
    for (int i = 0; i < DLY - 1; i++) begin
      chk(tx_start_o == 0, "R10 restarted delay", tx_start_o, 0);
      @(negedge clk);
    end
    chk(tx_start_o == 1, "R10 start", tx_start_o, 1);
    @(negedge clk);
    exp_cnt++;
    chk(char_count_o == exp_cnt, "R10 counted once", char_count_o, exp_cnt);
    // R5 counter wrap
    for (int i = 0; i < 14; i++)
      send(16'(8'h30 + i), 0, 8'(8'h30 + i), 0, "R5 wrap");
    // R1 reset mid-flight
    bus_wr(1'b1, 16'h0077);
    rst_ni = 0;
    @(negedge clk);
    rst_ni = 1;
    exp_cnt = '0;
    for (int i = 0; i < DLY + 2; i++) begin
      chk(tx_start_o == 0, "R1 no start after reset", tx_start_o, 0);
      @(negedge clk);
    end
    chk_stat(16'h0080, "R1 status after reset");
    chk(char_count_o == 0, "R1 count after reset", char_count_o, 0);
    chk(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule